// File: doc/BRIEF.md
# Host Indirect Memory Access Port Controller

This block lets an external host reach a processor's internal program and data memories through a narrow, strobe-driven port. The host shares a 16-bit data bus and has four active-low controls: a port select, an address-latch strobe, a read strobe and a write strobe. An address-latch cycle loads one of two things, picked by the top data bit. With the top bit clear it loads a start address and a memory space. With the top bit set it loads a pair of overlay page numbers. Each later read or write strobe becomes one request to the internal memory at the current address, and the address then advances by one. Reaching a paged bank therefore takes two latch cycles: one for the page numbers and one for the start address.

The processor core can write the same two registers at fixed data addresses, in either order, and read them back. A single acknowledge line tells the host when the port can take the next strobe. A static mode input sets how that line is driven. In open-drain mode the port only pulls the line low, so several ports can share it. In push-pull mode the port drives the line all the time.

The internal memories sit behind a request/grant handshake. The request carries the memory space, the 14-bit address, a 4-bit bank page and the write data.

Top module: `hostport_ctl`

## Requirements
- R1: After a synchronous active-low reset, the port is ready and makes no memory request. The control register (address, space) reads 0 and the overlay register reads 0, so every access uses bank page 0 until an overlay latch happens.
- R2: A latch strobe whose data has bit 15 = 0 loads bits 13:0 as the current address and bit 14 as the memory space (0 = program, 1 = data). The control register reads back as {0, space, address[13:0]}.
- R3: A latch strobe whose data has bit 15 = 1 loads the overlay register instead, and leaves the address and space unchanged. Overlay bits 3:0 are the data-memory page and bits 7:4 are the program-memory page.
- R4: Overlay register bits 15:8 are reserved. They always read 0, whatever value was written.
- R5: A core write to data address 0x3FE0 acts as a control-word latch (bit 15 picks overlay or address, as in R2 and R3). A core write to 0x3FE7 loads the overlay register directly. Both registers read back on core_rdata at those addresses, and the two writes can come in either order.
- R6: Each accepted read or write strobe produces exactly one memory request. The request carries the direction, the space, the current address and, for a write, the host data, and it is held stable until mem_gnt.
- R7: Each granted access increments the 14-bit address by one, wrapping from 0x3FFF to 0x0000.
- R8: The paged window is addresses 0x2000–0x3FFF for program memory and 0x0000–0x1FFF for data memory. Inside its window a request carries that space's overlay page. Outside it, the page is 0.
- R9: The port is busy from the accepted strobe until both conditions hold: two cycles have passed, and the grant has arrived. The busy time in cycles is therefore max(2, grant latency + 1). Any strobe, latch included, that starts while the port is busy is ignored.
- R10: When ack_od = 1 (open-drain), host_ack_out is 0 and host_ack_oe is 1 only while busy. When ack_od = 0 (push-pull), host_ack_oe is 1 and host_ack_out is 1 when ready and 0 when busy.
- R11: A read captures mem_rdata into host_rdata on the grant cycle, and host_rdata holds that value until the next read.
- R12: A strobe is recognised once, on its falling edge, and only while host_sel_n is low. A strobe with the port deselected has no effect. If read and write fall together, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_od | input | 1 | Static acknowledge mode: 1 open-drain, 0 push-pull |
| host_sel_n | input | 1 | Host port select, active low |
| host_latch_n | input | 1 | Host address/overlay latch strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 16 | Host data bus into the port |
| host_rdata | output | 16 | Data returned by the last read |
| host_ack_out | output | 1 | Acknowledge line level |
| host_ack_oe | output | 1 | Acknowledge line drive enable |
| core_wr_en | input | 1 | Core register write strobe |
| core_addr | input | 14 | Core data address for register write and readback |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Register readback at core_addr |
| mem_req | output | 1 | Internal memory request |
| mem_we | output | 1 | Request is a write |
| mem_space | output | 1 | 0 program memory, 1 data memory |
| mem_addr | output | 14 | Request address |
| mem_page | output | 4 | Bank page for the request |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Memory grant, completes the request |
| mem_rdata | input | 16 | Memory read data, valid with grant |

## Verification
The bench streams accesses across both window boundaries, 0x1FFF to 0x2000, in each space. A design that uses the wrong overlay field, or pages the wrong half of a space, shows up as a page mismatch on the very next request. It also wraps the address past 0x3FFF and latches overlay pages with the reserved bits set. It mixes core and host register writes in both orders, so a design that clobbers the address on an overlay latch, or leaks reserved bits, fails the readback. The busy window is timed at grant latencies of zero and four, and strobes are fired while busy and while deselected. A design that shortens acknowledge, or accepts strobes it should drop, produces a wrong cycle count or an unexpected request.

// File: rtl/hostport_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the host access port.
// Assumes: memory space is a single bit, program = 0, data = 1.
package hostport_pkg;
    typedef enum logic {
        SPACE_PM = 1'b0,
        SPACE_DM = 1'b1
    } space_e;
endpackage

// File: rtl/hostport_strobe.sv
`timescale 1ns/1ps
// Falling-edge detector for N active-low host strobes, gated by select.
// Assumes: strobes are synchronous to clk; one event per falling edge.
module hostport_strobe #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_strb
        // Remember the previous level of strobe i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= strb_n[i];
        end
        // An event is a high-to-low transition while the port is selected.
        assign evt[i] = prev_q[i] & ~strb_n[i] & ~sel_n;
    end
endmodule

// File: rtl/hostport_regs.sv
`timescale 1ns/1ps
// Control and overlay registers with core access and address stepping.
// Assumes: DW = AW + 2 (bit DW-1 picks overlay, bit DW-2 is the space).
// A core write takes priority over a host latch in the same cycle.
module hostport_regs
    import hostport_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          AW        = 14,
    parameter int          PGW       = 4,
    parameter logic [13:0] CTRL_ADDR = 14'h3FE0,
    parameter logic [13:0] OVL_ADDR  = 14'h3FE7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           latch_evt,
    input  logic [DW-1:0]  host_din,
    input  logic           core_wr_en,
    input  logic [AW-1:0]  core_addr,
    input  logic [DW-1:0]  core_wdata,
    input  logic           addr_inc,
    output logic [AW-1:0]  cur_addr,
    output space_e         cur_space,
    output logic [PGW-1:0] pm_page,
    output logic [PGW-1:0] dm_page,
    output logic [DW-1:0]  core_rdata
);
    localparam int OVW     = 2 * PGW;
    localparam int SEL_BIT = DW - 1;
    localparam int SPC_BIT = DW - 2;

    logic [OVW-1:0] ovl_q;
    logic [AW-1:0]  addr_q;
    space_e         space_q;
    logic           ctl_go;
    logic [DW-1:0]  ctl_word;
    logic           ovl_go;

    // Pick the source of a control-word load: core first, else host latch.
    always_comb begin
        ctl_go   = latch_evt;
        ctl_word = host_din;
        if (core_wr_en && core_addr == CTRL_ADDR) begin
            ctl_go   = 1'b1;
            ctl_word = core_wdata;
        end
        ovl_go = core_wr_en && (core_addr == OVL_ADDR);
    end

    // Overlay register: direct core write or control word with select bit set.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ovl_q <= '0;
        else if (ovl_go)                    ovl_q <= core_wdata[OVW-1:0];
        else if (ctl_go && ctl_word[SEL_BIT]) ovl_q <= ctl_word[OVW-1:0];
    end

    // Address and space: load from a control word, else step after an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            space_q <= SPACE_PM;
        end else if (ctl_go && !ctl_word[SEL_BIT]) begin
            addr_q  <= ctl_word[AW-1:0];
            space_q <= space_e'(ctl_word[SPC_BIT]);
        end else if (addr_inc) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

    // Readback mux for the core; reserved bits stay zero.
    always_comb begin
        core_rdata = '0;
        if (core_addr == CTRL_ADDR) begin
            core_rdata[AW-1:0]  = addr_q;
            core_rdata[SPC_BIT] = space_q;
        end else if (core_addr == OVL_ADDR) begin
            core_rdata[OVW-1:0] = ovl_q;
        end
    end

    assign cur_addr  = addr_q;
    assign cur_space = space_q;
    assign pm_page   = ovl_q[OVW-1:PGW];
    assign dm_page   = ovl_q[PGW-1:0];
endmodule

// File: rtl/hostport_xfer.sv
`timescale 1ns/1ps
// Access sequencer: turns accepted strobes into memory requests and
// times the busy window (minimum BUSY_CYC cycles and until grant).
// Assumes: strobes arriving while busy are dropped; write beats read.
module hostport_xfer #(
    parameter int DW       = 16,
    parameter int BUSY_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_evt,
    input  logic          wr_evt,
    input  logic [DW-1:0] host_din,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          addr_inc,
    output logic [DW-1:0] host_rdata
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] BUSY_LD = CW'(BUSY_CYC);

    logic          pend_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic [CW-1:0] cnt_q;
    logic          start;

    assign busy     = pend_q || (cnt_q != '0);
    assign start    = (rd_evt || wr_evt) && !busy;
    assign addr_inc = pend_q && mem_gnt;

    // Launch an access, count down the minimum window, retire on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            pend_q <= 1'b1;
            we_q   <= wr_evt;
            cnt_q  <= BUSY_LD;
            if (wr_evt) wdata_q <= host_din;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (pend_q && mem_gnt) begin
                pend_q <= 1'b0;
                if (!we_q) rdata_q <= mem_rdata;
            end
        end
    end

    assign mem_req    = pend_q;
    assign mem_we     = we_q;
    assign mem_wdata  = wdata_q;
    assign host_rdata = rdata_q;
endmodule

// File: rtl/hostport_ack.sv
`timescale 1ns/1ps
// Acknowledge line driver: open-drain (pull low while busy) or push-pull.
// Assumes: od_mode is static during operation.
module hostport_ack (
    input  logic busy,
    input  logic od_mode,
    output logic ack_out,
    output logic ack_oe
);
    // Choose level and enable from the drive mode.
    always_comb begin
        if (od_mode) begin
            ack_out = 1'b0;
            ack_oe  = busy;
        end else begin
            ack_out = ~busy;
            ack_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/hostport_ctl.sv
`timescale 1ns/1ps
// Host indirect memory access port: strobe decode, register file,
// access sequencing, bank page selection and acknowledge drive.
// Assumes: host strobes synchronous to clk; core does not rewrite the
// control register while an access is outstanding.
module hostport_ctl
    import hostport_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          AW        = 14,
    parameter int          PGW       = 4,
    parameter int          BUSY_CYC  = 2,
    parameter logic [13:0] CTRL_ADDR = 14'h3FE0,
    parameter logic [13:0] OVL_ADDR  = 14'h3FE7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ack_od,
    input  logic           host_sel_n,
    input  logic           host_latch_n,
    input  logic           host_rd_n,
    input  logic           host_wr_n,
    input  logic [DW-1:0]  host_din,
    output logic [DW-1:0]  host_rdata,
    output logic           host_ack_out,
    output logic           host_ack_oe,
    input  logic           core_wr_en,
    input  logic [AW-1:0]  core_addr,
    input  logic [DW-1:0]  core_wdata,
    output logic [DW-1:0]  core_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_space,
    output logic [AW-1:0]  mem_addr,
    output logic [PGW-1:0] mem_page,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_gnt,
    input  logic [DW-1:0]  mem_rdata
);
    localparam int NSTRB = 3;
    localparam int IX_LATCH = 0;
    localparam int IX_RD    = 1;
    localparam int IX_WR    = 2;

    logic [NSTRB-1:0] evt;
    logic [AW-1:0]    cur_addr;
    space_e           cur_space;
    logic [PGW-1:0]   pm_page;
    logic [PGW-1:0]   dm_page;
    logic             addr_inc;
    logic             busy;
    logic             latch_ok;
    logic             in_window;

    hostport_strobe #(.N(NSTRB)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (host_sel_n),
        .strb_n ({host_wr_n, host_rd_n, host_latch_n}),
        .evt    (evt)
    );

    // Latch cycles are dropped while an access is in progress.
    assign latch_ok = evt[IX_LATCH] && !busy;

    hostport_regs #(
        .DW(DW), .AW(AW), .PGW(PGW),
        .CTRL_ADDR(CTRL_ADDR), .OVL_ADDR(OVL_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_evt  (latch_ok),
        .host_din   (host_din),
        .core_wr_en (core_wr_en),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .addr_inc   (addr_inc),
        .cur_addr   (cur_addr),
        .cur_space  (cur_space),
        .pm_page    (pm_page),
        .dm_page    (dm_page),
        .core_rdata (core_rdata)
    );

    hostport_xfer #(.DW(DW), .BUSY_CYC(BUSY_CYC)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt     (evt[IX_RD]),
        .wr_evt     (evt[IX_WR]),
        .host_din   (host_din),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .addr_inc   (addr_inc),
        .host_rdata (host_rdata)
    );

    hostport_ack u_ack (
        .busy    (busy),
        .od_mode (ack_od),
        .ack_out (host_ack_out),
        .ack_oe  (host_ack_oe)
    );

    // Bank page: program pages the upper half, data pages the lower half.
    always_comb begin
        in_window = (cur_space == SPACE_PM) ? cur_addr[AW-1] : !cur_addr[AW-1];
        if (!in_window)                mem_page = '0;
        else if (cur_space == SPACE_PM) mem_page = pm_page;
        else                           mem_page = dm_page;
    end

    assign mem_addr  = cur_addr;
    assign mem_space = cur_space;
endmodule

// File: rtl/hostport_ctl_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for hostport_ctl, attached by bind.
module hostport_ctl_chk #(
    parameter int          DW       = 16,
    parameter int          AW       = 14,
    parameter logic [13:0] OVL_ADDR = 14'h3FE7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_od,
    input logic          host_ack_out,
    input logic          host_ack_oe,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          core_wr_en,
    input logic [AW-1:0] core_addr,
    input logic [DW-1:0] core_rdata
);
    logic busy_w;
    assign busy_w = ack_od ? host_ack_oe : !host_ack_out;

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_od |-> !host_ack_out); // R10
    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (core_addr == OVL_ADDR) |-> (core_rdata[DW-1:8] == '0)); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !core_wr_en) |=> (mem_req && $stable(mem_addr))); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !core_wr_en) |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R7
    AST_BUSY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |=> busy_w); // R9
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> !mem_req); // R9
endmodule

bind hostport_ctl hostport_ctl_chk #(.DW(DW), .AW(AW), .OVL_ADDR(OVL_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_od       (ack_od),
    .host_ack_out (host_ack_out),
    .host_ack_oe  (host_ack_oe),
    .mem_req      (mem_req),
    .mem_gnt      (mem_gnt),
    .mem_addr     (mem_addr),
    .core_wr_en   (core_wr_en),
    .core_addr    (core_addr),
    .core_rdata   (core_rdata)
);

// File: tb/hostport_ctl_test.sv
`timescale 1ns/1ps
module hostport_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack_od = 1'b0;
    logic        host_sel_n = 1'b1;
    logic        host_latch_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [15:0] host_din = '0;
    logic [15:0] host_rdata;
    logic        host_ack_out;
    logic        host_ack_oe;
    logic        core_wr_en = 1'b0;
    logic [13:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        mem_req;
    logic        mem_we;
    logic        mem_space;
    logic [13:0] mem_addr;
    logic [3:0]  mem_page;
    logic [15:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [15:0] mem_rdata;

    localparam logic [13:0] A_CTRL = 14'h3FE0;
    localparam logic [13:0] A_OVL  = 14'h3FE7;

    hostport_ctl uut (.*);

    always #2 clk = ~clk;

    assign mem_rdata = {2'b00, mem_addr} ^ 16'hA5A5;

    typedef struct {
        bit          we;
        bit          space;
        logic [13:0] addr;
        logic [3:0]  page;
        logic [15:0] wdata;
        string       req;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int grants = 0;
    int gnt_delay = 0;
    int wcnt = 0;
    bit done = 1'b0;

    // bench model of the register state
    logic [13:0] m_addr = '0;
    bit          m_space = 1'b0;
    logic [3:0]  m_pm = '0;
    logic [3:0]  m_dm = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_page(input bit sp, input logic [13:0] a);
        if (!sp && a >= 14'h2000) return m_pm;   // R8 program window
        if (sp && a < 14'h2000)   return m_dm;   // R8 data window
        return 4'h0;
    endfunction

    function automatic bit obs_busy();
        return ack_od ? host_ack_oe : !host_ack_out;
    endfunction

    // Memory model plus scoreboard monitor: grant and compare on the same negedge.
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            wcnt = 0;
            mem_gnt = 1'b0;
        end else begin
            mem_gnt = (wcnt >= gnt_delay);
            wcnt++;
            if (mem_gnt) begin
                grants++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected request addr", int'(mem_addr), 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we, e.req, "direction", int'(mem_we), int'(e.we));
                    chk(mem_space == e.space, e.req, "space", int'(mem_space), int'(e.space));
                    chk(mem_addr == e.addr, e.req, "address", int'(mem_addr), int'(e.addr));
                    chk(mem_page == e.page, e.req, "page", int'(mem_page), int'(e.page));
                    if (e.we)
                        chk(mem_wdata == e.wdata, e.req, "wdata", int'(mem_wdata), int'(e.wdata));
                end
            end
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        while (obs_busy()) @(negedge clk);
    endtask

    // 0 latch, 1 read, 2 write; one-cycle strobe with select low
    task automatic pulse(input int which, input logic [15:0] d, input bit sel);
        host_sel_n = !sel;
        host_din = d;
        if (which == 0) host_latch_n = 1'b0;
        if (which == 1) host_rd_n = 1'b0;
        if (which == 2) host_wr_n = 1'b0;
        @(negedge clk);
        host_sel_n = 1'b1;
        host_latch_n = 1'b1;
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
    endtask

    task automatic host_latch(input logic [15:0] w);
        wait_ready();
        pulse(0, w, 1'b1);
        if (w[15]) begin m_pm = w[7:4]; m_dm = w[3:0]; end
        else begin m_addr = w[13:0]; m_space = w[14]; end
    endtask

    task automatic host_write(input logic [15:0] d, input string req);
        item_t e;
        wait_ready();
        e.we = 1'b1; e.space = m_space; e.addr = m_addr;
        e.page = exp_page(m_space, m_addr); e.wdata = d; e.req = req;
        exp_q.push_back(e);
        pulse(2, d, 1'b1);
        m_addr = m_addr + 1'b1;
    endtask

    task automatic host_read(input string req);
        item_t e;
        logic [15:0] xd;
        wait_ready();
        e.we = 1'b0; e.space = m_space; e.addr = m_addr;
        e.page = exp_page(m_space, m_addr); e.wdata = '0; e.req = req;
        xd = {2'b00, m_addr} ^ 16'hA5A5;
        exp_q.push_back(e);
        pulse(1, '0, 1'b1);
        m_addr = m_addr + 1'b1;
        wait_ready();
        chk(host_rdata == xd, "R11", "read data", int'(host_rdata), int'(xd));
    endtask

    task automatic readback(input logic [13:0] a, input logic [15:0] x, input string req);
        core_addr = a;
        #1;
        chk(core_rdata == x, req, "register readback", int'(core_rdata), int'(x));
        core_addr = '0;
    endtask

    task automatic core_write(input logic [13:0] a, input logic [15:0] d);
        @(negedge clk);
        core_wr_en = 1'b1; core_addr = a; core_wdata = d;
        @(negedge clk);
        core_wr_en = 1'b0; core_addr = '0;
    endtask

    // Time the busy window of one write at a given grant latency.
    task automatic busy_len(input int d, input int expn, input string req);
        int n;
        gnt_delay = d;
        wait_ready();
        host_write(16'h0BEE, req);
        n = 1; // the negedge after the strobe release is already inside the window
        chk(obs_busy() == 1'b1, "R9", "busy after strobe", 0, 1);
        if (ack_od)
            chk(host_ack_oe == 1'b1 && host_ack_out == 1'b0, "R10", "open-drain busy drive",
                int'({host_ack_oe, host_ack_out}), 2);
        else
            chk(host_ack_oe == 1'b1 && host_ack_out == 1'b0, "R10", "push-pull busy level",
                int'({host_ack_oe, host_ack_out}), 2);
        @(negedge clk);
        while (obs_busy()) begin n++; @(negedge clk); end
        chk(n == expn, "R9", "busy cycles", n, expn);
        if (ack_od)
            chk(host_ack_oe == 1'b0 && host_ack_out == 1'b0, "R10", "open-drain released",
                int'({host_ack_oe, host_ack_out}), 0);
        else
            chk(host_ack_oe == 1'b1 && host_ack_out == 1'b1, "R10", "push-pull ready level",
                int'({host_ack_oe, host_ack_out}), 3);
    endtask

    initial begin
        int g0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_req == 1'b0, "R1", "request after reset", int'(mem_req), 0);
        chk(!obs_busy(), "R1", "busy after reset", int'(obs_busy()), 0);
        readback(A_CTRL, 16'h0000, "R1");
        readback(A_OVL, 16'h0000, "R1");

        // R2 address latch into data space, default page
        host_latch(16'h4010);
        wait_ready();
        readback(A_CTRL, 16'h4010, "R2");
        host_write(16'h1111, "R1");

        // R3 overlay latch keeps the address
        host_latch(16'h8025);
        wait_ready();
        readback(A_OVL, 16'h0025, "R3");
        readback(A_CTRL, 16'h4011, "R3");

        // R8 data window boundary 0x1FFF -> 0x2000
        host_latch(16'h5FFF);
        host_write(16'h2222, "R8");
        host_write(16'h3333, "R8");

        // R8 program window boundary with reads
        host_latch(16'h1FFF);
        host_read("R8");
        host_read("R8");

        // R7 wrap at 0x3FFF
        host_latch(16'h3FFF);
        host_write(16'h4444, "R7");
        host_write(16'h5555, "R7");
        wait_ready();
        readback(A_CTRL, 16'h0001, "R7");

        // R4 / R5 core writes, overlay first then control
        core_write(A_OVL, 16'hFFFF);
        m_pm = 4'hF; m_dm = 4'hF;
        readback(A_OVL, 16'h00FF, "R4");
        core_write(A_CTRL, 16'h4100);
        m_addr = 14'h0100; m_space = 1'b1;
        readback(A_CTRL, 16'h4100, "R5");
        host_write(16'h6666, "R5");
        // control first then overlay through the control address
        core_write(A_CTRL, 16'h2200);
        m_addr = 14'h2200; m_space = 1'b0;
        core_write(A_CTRL, 16'h8031);
        m_pm = 4'h3; m_dm = 4'h1;
        readback(A_OVL, 16'h0031, "R5");
        host_write(16'h7777, "R5");

        // R9 / R10 busy window in both acknowledge modes
        ack_od = 1'b0;
        busy_len(0, 2, "R9");
        ack_od = 1'b1;
        busy_len(4, 5, "R9");
        ack_od = 1'b0;

        // R9 strobes and latches during busy are ignored
        gnt_delay = 6;
        wait_ready();
        g0 = grants;
        host_write(16'h8888, "R9");
        pulse(2, 16'h9999, 1'b1);
        @(negedge clk);
        pulse(0, 16'h4AAA, 1'b1);
        wait_ready();
        repeat (3) @(negedge clk);
        chk(grants == g0 + 1, "R9", "requests for one accepted strobe", grants - g0, 1);
        gnt_delay = 0;
        host_write(16'hABCD, "R9");

        // R12 deselected strobe has no effect
        wait_ready();
        g0 = grants;
        pulse(2, 16'h1234, 1'b0);
        repeat (4) @(negedge clk);
        chk(grants == g0, "R12", "request from deselected strobe", grants - g0, 0);
        chk(!obs_busy(), "R12", "busy from deselected strobe", int'(obs_busy()), 0);
        readback(A_CTRL, {2'b00, m_addr}, "R12");

        // R6 every expected request was seen
        wait_ready();
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "missing requests", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule